// File: doc/BRIEF.md
# Audio Clock Ratio Speed Detector

This block watches a frame (left/right) clock that arrives asynchronously to the master clock and measures each frame period in master clock cycles. The count is matched against a small set of legal integer ratios, and the block then reports which ratio it found and whether the stream runs at single speed or double speed. A configuration bit tells the block that the master clock runs at twice its nominal rate. The block then halves the raw count before matching, so one raw count can land in different speed modes depending on that bit.

Results are only trusted once the same ratio has been seen on several consecutive frames. Any frame whose length matches no legal ratio drops the valid indication straight away. So does a frame clock that stops toggling. A clocking supervisor uses the outputs to choose filter and interpolation settings, and to hold the data path quiet while the clocks are unsettled.

Top module: `aclk_ratio_detect`

## Requirements
- R1: After reset, and until a result is locked, `ratio_valid` is 0, `ratio_code` is 7 and `double_speed` is 0.
- R2: With `mclk_div2` low, frame periods of 128, 192, 256, 384 and 512 master cycles give the ratio codes 0, 1, 2, 3 and 4 in that order. Code 7 means no valid ratio.
- R3: `double_speed` is 1 only while a valid code 0 or 1 is reported (effective ratio 128 or 192). For codes 2, 3 and 4, and whenever the result is invalid, it is 0.
- R4: With `mclk_div2` high, the raw period must be even, and half of it is matched as in R2. Raw 256 and 384 report codes 0 and 1 (double speed). Raw 512, 768 and 1024 report codes 2, 3 and 4 (single speed).
- R5: A period that matches no legal ratio drops `ratio_valid` and forces code 7 at the update for that frame. This covers a count off by one cycle, 1024 with `mclk_div2` low, and an odd count with `mclk_div2` high.
- R6: A period is measured from one rising frame edge to the next, so the first rising edge after reset gives no result. `ratio_valid` rises only after three consecutive identical measurements, and a differing measurement clears it.
- R7: If no rising frame edge arrives for 1024 master cycles after the previous one, `ratio_valid` drops at once. It stays high at any earlier point.
- R8: The frame input passes through a two-stage synchronizer followed by an edge register. A rising level first sampled at clock edge k updates the outputs at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clk | input | 1 | Frame (left/right) clock, asynchronous to `mclk` |
| mclk_div2 | input | 1 | Master clock is double rate; halve the count before matching |
| ratio_code | output | 3 | Locked ratio code (0..4), 7 when not valid |
| double_speed | output | 1 | High for a locked double-speed ratio |
| ratio_valid | output | 1 | Ratio locked and stable |

## Verification
A behavioural model in the bench keeps the last three samples of the frame input and a cycle counter. It derives each measurement and the lock run from the requirements, and the outputs are compared with it on every falling clock edge. A rising frame level sampled at one clock edge shows up in the outputs two edges later (R8). The measurement and its classification land at that same edge, with no extra register. A timeout takes effect at the edge where the count since the last rising edge has reached 1024. Directed checks run only after a whole sequence of frames has been driven, when every update is long settled. Each one states the code and valid state expected after exactly that many measurements.

// File: rtl/aclk_ratio_pkg.sv
// Shared constants and helpers for the clock ratio detector.
// Assumes the ratio codes are dense from 0 and that code 7 is free to mean "invalid".
package aclk_ratio_pkg;

    localparam int unsigned CODE_W = 3;
    localparam logic [CODE_W-1:0] CODE_INVALID = 3'd7;

    // Effective ratio for code idx: even codes are base<<k, odd codes are 1.5*base<<k.
    function automatic int unsigned code_ratio(int unsigned base, int unsigned idx);
        int unsigned step;
        step = ((idx % 2) != 0) ? (base * 3) / 2 : base;
        return step << (idx / 2);
    endfunction

endpackage

// File: rtl/aclk_frame_sync.sv
// Brings the asynchronous frame clock into the master domain and flags rising edges.
// Assumes the frame clock high and low phases each last several master cycles.
module aclk_frame_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_async,
    output logic rise_o
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-stage synchronizer plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= frame_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // A rising edge is a new high level after a low one.
    assign rise_o = sync_q & ~prev_q;

    // R8: an edge pulse lasts exactly one cycle.
    p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/aclk_period_counter.sv
// Counts master cycles between rising frame edges and reports each completed period.
// Assumes the first edge after reset only opens a measurement. The count saturates just above MAX_RAW.
module aclk_period_counter #(
    parameter int unsigned MAX_RAW = 1024,
    parameter int unsigned CNT_W   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    output logic             meas_stb_o,
    output logic [CNT_W-1:0] period_o,
    output logic             timeout_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             primed_q;

    // Restart at 1 on an edge; otherwise count up and hold once past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            primed_q <= 1'b0;
        end else if (rise_i) begin
            cnt_q    <= CNT_W'(1);
            primed_q <= 1'b1;
        end else if (cnt_q <= CNT_W'(MAX_RAW)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign meas_stb_o = rise_i & primed_q;
    assign period_o   = cnt_q;
    assign timeout_o  = ~rise_i & (cnt_q >= CNT_W'(MAX_RAW));

    // R7: a fresh measurement restarts the count, so no timeout can follow straight after.
    p_no_timeout_after_meas_r7: assert property (@(posedge clk) disable iff (!rst_n)
        meas_stb_o |=> !timeout_o);

endmodule

// File: rtl/aclk_ratio_classify.sv
// Matches a measured period against the legal ratio set and returns its code.
// Assumes the ratio table is ascending, so a lower code wins if two entries ever coincide.
module aclk_ratio_classify
    import aclk_ratio_pkg::*;
#(
    parameter int unsigned BASE_RATIO = 128,
    parameter int unsigned NUM_CODES  = 5,
    parameter int unsigned CNT_W      = 11
) (
    input  logic [CNT_W-1:0]  period_i,
    input  logic              half_i,
    output logic [CODE_W-1:0] code_o,
    output logic              match_o
);

    logic [CNT_W-1:0]     eff;
    logic                 eff_ok;
    logic [NUM_CODES-1:0] hit;

    // A halved master clock needs an even raw count before halving.
    assign eff    = half_i ? (period_i >> 1) : period_i;
    assign eff_ok = ~(half_i & period_i[0]);

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_cmp
        assign hit[i] = eff_ok && (eff == CNT_W'(code_ratio(BASE_RATIO, i)));
    end

    // Pick the lowest matching code, or the invalid code when none matches.
    always_comb begin
        code_o = CODE_INVALID;
        for (int i = NUM_CODES - 1; i >= 0; i--) begin
            if (hit[i]) code_o = CODE_W'(i);
        end
    end

    assign match_o = |hit;

endmodule

// File: rtl/aclk_lock_filter.sv
// Holds the last ratio code and asserts valid after LOCK_FRAMES identical measurements.
// Assumes the measurement strobe and the timeout are never high in the same cycle.
module aclk_lock_filter
    import aclk_ratio_pkg::*;
#(
    parameter int unsigned NUM_CODES   = 5,
    parameter int unsigned DBL_CODES   = 2,
    parameter int unsigned LOCK_FRAMES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_stb_i,
    input  logic              match_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              timeout_i,
    output logic [CODE_W-1:0] ratio_code_o,
    output logic              double_o,
    output logic              valid_o
);

    localparam int unsigned RUN_W = $clog2(LOCK_FRAMES + 1);
    localparam logic [RUN_W-1:0] RUN_LOCK = RUN_W'(LOCK_FRAMES);

    logic [CODE_W-1:0] last_q;
    logic [RUN_W-1:0]  run_q;
    logic              valid_q;
    logic [RUN_W-1:0]  run_inc;

    assign run_inc = (run_q == RUN_LOCK) ? run_q : run_q + RUN_W'(1);

    // Track the run of identical codes; a bad frame or a timeout clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= CODE_INVALID;
            run_q   <= '0;
            valid_q <= 1'b0;
        end else if (timeout_i || (meas_stb_i && !match_i)) begin
            last_q  <= CODE_INVALID;
            run_q   <= '0;
            valid_q <= 1'b0;
        end else if (meas_stb_i && code_i == last_q) begin
            run_q   <= run_inc;
            valid_q <= (run_inc >= RUN_LOCK);
        end else if (meas_stb_i) begin
            last_q  <= code_i;
            run_q   <= RUN_W'(1);
            valid_q <= (LOCK_FRAMES <= 1);
        end
    end

    assign valid_o      = valid_q;
    assign ratio_code_o = valid_q ? last_q : CODE_INVALID;
    assign double_o     = valid_q && (last_q < CODE_W'(DBL_CODES));

    // R2: a matched measurement always carries a code from the legal set.
    p_match_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_stb_i && match_i) |-> (code_i < CODE_W'(NUM_CODES)));

    // R5: a measurement matching no ratio leaves valid low on the next cycle.
    p_mismatch_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_stb_i && !match_i) |=> !valid_o);

    // R6: valid only rises on the cycle after a measurement.
    p_valid_rise_on_meas_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(meas_stb_i));

    // R7: a timeout leaves valid low on the next cycle.
    p_timeout_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_i |=> !valid_o);

endmodule

// File: rtl/aclk_ratio_detect.sv
// Top level: synchronize the frame clock, measure its period, classify it and filter for lock.
// Assumes mclk_div2 is static or changes only while the result is not relied upon.
module aclk_ratio_detect
    import aclk_ratio_pkg::*;
#(
    parameter int unsigned BASE_RATIO  = 128,
    parameter int unsigned NUM_CODES   = 5,
    parameter int unsigned DBL_CODES   = 2,
    parameter int unsigned LOCK_FRAMES = 3
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              frame_clk,
    input  logic              mclk_div2,
    output logic [CODE_W-1:0] ratio_code,
    output logic              double_speed,
    output logic              ratio_valid
);

    localparam int unsigned MAX_EFF = code_ratio(BASE_RATIO, NUM_CODES - 1);
    localparam int unsigned MAX_RAW = 2 * MAX_EFF;
    localparam int unsigned CNT_W   = $clog2(MAX_RAW + 2);

    logic              rise;
    logic              meas_stb;
    logic              timeout;
    logic [CNT_W-1:0]  period;
    logic [CODE_W-1:0] code;
    logic              match;

    aclk_frame_sync u_sync (
        .clk         (mclk),
        .rst_n       (rst_n),
        .frame_async (frame_clk),
        .rise_o      (rise)
    );

    aclk_period_counter #(.MAX_RAW(MAX_RAW), .CNT_W(CNT_W)) u_count (
        .clk        (mclk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .meas_stb_o (meas_stb),
        .period_o   (period),
        .timeout_o  (timeout)
    );

    aclk_ratio_classify #(.BASE_RATIO(BASE_RATIO), .NUM_CODES(NUM_CODES), .CNT_W(CNT_W)) u_class (
        .period_i (period),
        .half_i   (mclk_div2),
        .code_o   (code),
        .match_o  (match)
    );

    aclk_lock_filter #(.NUM_CODES(NUM_CODES), .DBL_CODES(DBL_CODES), .LOCK_FRAMES(LOCK_FRAMES)) u_lock (
        .clk          (mclk),
        .rst_n        (rst_n),
        .meas_stb_i   (meas_stb),
        .match_i      (match),
        .code_i       (code),
        .timeout_i    (timeout),
        .ratio_code_o (ratio_code),
        .double_o     (double_speed),
        .valid_o      (ratio_valid)
    );

    // R3: the double-speed flag only accompanies the two lowest codes.
    p_double_low_codes_r3: assert property (@(posedge mclk) disable iff (!rst_n)
        double_speed |-> (ratio_valid && ratio_code < CODE_W'(DBL_CODES)));

    // R1: without a lock the code always reads invalid.
    p_invalid_code_r1: assert property (@(posedge mclk) disable iff (!rst_n)
        !ratio_valid |-> (ratio_code == CODE_INVALID && !double_speed));

endmodule

// File: tb/aclk_ratio_detect_tb_top.sv
// Bench: a behavioural reference model compared on every cycle, plus directed checks per requirement.
module aclk_ratio_detect_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_in = 1'b0;
    logic       half = 1'b0;
    logic [2:0] ratio_code;
    logic       double_speed;
    logic       ratio_valid;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    aclk_ratio_detect dut_i (
        .mclk         (clk),
        .rst_n        (rst_n),
        .frame_clk    (frame_in),
        .mclk_div2    (half),
        .ratio_code   (ratio_code),
        .double_speed (double_speed),
        .ratio_valid  (ratio_valid)
    );

    // Reference model state.
    bit hist[$];
    int m_cnt;
    bit m_primed;
    int m_last;
    int m_run;
    bit m_valid;

    function automatic int classify(int raw, bit h);
        int e;
        if (h) begin
            if (raw % 2 != 0) return 7;
            e = raw / 2;
        end else begin
            e = raw;
        end
        case (e)
            128: return 0;
            192: return 1;
            256: return 2;
            384: return 3;
            512: return 4;
            default: return 7;
        endcase
    endfunction

    // Model update at each rising edge, from R5..R8.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{1'b0, 1'b0, 1'b0};
            m_cnt = 0; m_primed = 0; m_last = 7; m_run = 0; m_valid = 0;
        end else begin
            bit rise;
            int c;
            rise = hist[1] && !hist[2];
            if (rise) begin
                if (m_primed) begin
                    c = classify(m_cnt, half);
                    if (c == 7) begin
                        m_last = 7; m_run = 0;
                    end else if (c == m_last) begin
                        m_run = (m_run < 3) ? m_run + 1 : 3;
                    end else begin
                        m_last = c; m_run = 1;
                    end
                    m_valid = (m_run >= 3);
                end
                m_primed = 1; m_cnt = 1;
            end else begin
                if (m_cnt >= 1024) begin
                    m_last = 7; m_run = 0; m_valid = 0;
                end
                if (m_cnt <= 1024) m_cnt++;
            end
            hist.push_front(frame_in);
            void'(hist.pop_back());
        end
    end

    // Per-cycle comparison with the model (R8 timing, R2/R3 values).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int ec;
            bit ed;
            ec = m_valid ? m_last : 7;
            ed = m_valid && (m_last <= 1);
            n_tests++;
            if (ratio_valid !== m_valid || ratio_code !== 3'(ec) || double_speed !== ed) begin
                n_fail++;
                $display("FAIL R8 model t=%0t actual v=%0d c=%0d d=%0d expected v=%0d c=%0d d=%0d",
                         $time, ratio_valid, ratio_code, double_speed, m_valid, ec, ed);
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic frame(int n);
        frame_in = 1'b1;
        repeat (n / 2) @(negedge clk);
        frame_in = 1'b0;
        repeat (n - n / 2) @(negedge clk);
    endtask

    task automatic frames(int n, int k);
        for (int i = 0; i < k; i++) frame(n);
    endtask

    task automatic check_lock(string req, int code, int dbl);
        check({req, " valid"}, int'(ratio_valid), 1);
        check({req, " code"}, int'(ratio_code), code);
        check({req, " double"}, int'(double_speed), dbl);
    endtask

    task automatic check_unlocked(string req);
        check({req, " valid"}, int'(ratio_valid), 0);
        check({req, " code"}, int'(ratio_code), 7);
        check({req, " double"}, int'(double_speed), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check_unlocked("R1 in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_unlocked("R1 after reset");

        // R6: three measurements need four rising edges; the third frame alone is not enough.
        frames(256, 3);
        check_unlocked("R6 two measurements");
        frame(256);
        check_lock("R2 R3 ratio 256", 2, 0);

        frames(128, 4);  check_lock("R2 R3 ratio 128", 0, 1);
        frames(192, 4);  check_lock("R2 R3 ratio 192", 1, 1);
        frames(384, 4);  check_lock("R2 ratio 384", 3, 0);
        frames(512, 4);  check_lock("R2 ratio 512", 4, 0);

        // R5: 1024 without halving is illegal.
        frames(1024, 2);
        check_unlocked("R5 raw 1024 undivided");

        // R4: halved master clock.
        half = 1'b1;
        frames(768, 4);  check_lock("R4 raw 768", 3, 0);
        frames(256, 4);  check_lock("R4 raw 256", 0, 1);
        frames(384, 4);  check_lock("R4 raw 384", 1, 1);
        frames(1024, 4); check_lock("R4 raw 1024", 4, 0);
        frames(512, 4);  check_lock("R4 raw 512", 2, 0);
        frames(513, 2);
        check_unlocked("R5 odd count halved");
        half = 1'b0;

        // R5: off by one cycle drops lock at once; relock after three good frames.
        frames(256, 5);
        check_lock("R5 pre lock", 2, 0);
        frame(257);
        frame(256);
        check_unlocked("R5 off by one");
        frames(256, 3);
        check_lock("R6 relock", 2, 0);

        // R6: alternating ratios never lock.
        for (int i = 0; i < 4; i++) begin
            frame(256);
            frame(384);
        end
        check_unlocked("R6 alternating");

        // R7: a stopped frame clock times out after 1024 cycles.
        frames(128, 4);
        repeat (600) @(negedge clk);
        check_lock("R7 before timeout", 0, 1);
        repeat (500) @(negedge clk);
        check_unlocked("R7 after timeout");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule